// File: doc/BRIEF.md
# Parallel Port Peripheral Register Interface

This block is the register and pin-conditioning layer on the peripheral side of an IEEE 1284 parallel port. Host control lines (INIT, AUTOFD, STROBE, SELECTIN) and the eight data lines pass through two-flop synchronizers. The control lines then pass through an optional stability filter. A falling edge of the conditioned STROBE latches the synchronized data byte, and the synchronized AUTOFD level is latched with it as a command flag. While DMA is enabled, that same edge also raises a DMA request.

When output drive is enabled, the block stops capturing and drives the data register onto the bus. A separate handshake state machine supplies ACK and BUSY assertions as inputs. The block merges these with software force bits to form the ACK and BUSY pins, and software can read back the levels actually driven. The PERROR pin follows a control bit.

A CPU reaches four byte registers through a simple port. Reads are combinational on the address. A write takes effect at the next clock edge.

Top module: `ppr_periph_regs`

## Requirements
- R1: While control bit 0 (drive enable) is 0, a falling edge of the conditioned STROBE loads the synchronized data bus into the data register (address 0). While bit 0 is 1, strobe edges leave the data register unchanged.
- R2: `pd_oe_o` equals control bit 0. `pd_o` presents the data register, with register bit 7 on bus line 7 and bit 0 on line 0. CPU writes to address 0 load the data register.
- R3: Each capture also loads the synchronized AUTOFD level into the command flag, which reads at address 1 bit 0.
- R4: A capture while control bit 1 (DMA enable) is 1 sets `dma_req_o`. A capture while bit 1 is 0 leaves it at 0.
- R5: `dma_req_o` clears on `dma_ack_i`, or on a CPU read of address 0 or 1 while DMA is enabled. A read of address 2 does not clear it.
- R6: With control bit 2 (filter enable) at 0, status bits at address 3 follow their pins: bit 0 INIT, bit 1 AUTOFD, bit 2 STROBE, bit 3 SELECTIN. A pin change appears on the third rising edge after it, and not before.
- R7: With the filter enabled, a new control-line level is accepted only after it has been seen for FILT_LEN consecutive clocks after synchronization. With the default of 3, this is the fifth rising edge after the pin change. A pulse of 2 clocks never reaches the status.
- R8: `ack_o` is low when control bit 3 (ACK force) is 1 or `sm_ack_i` is 1, and high otherwise. Status bit 4 reads the driven ACK level.
- R9: `busy_o` is high when control bit 4 (BUSY force) is 1 or `sm_busy_i` is 1, and low otherwise. Status bit 5 reads the driven BUSY level.
- R10: After reset, the control register reads 0x10 (BUSY force set). Status reads 0x3F with idle-high pins. The data register is 0, the command flag is 0, `dma_req_o` is 0, `busy_o` is 1 and `ack_o` is 1.
- R11: `perror_o` follows control bit 5.
- R12: CPU writes to address 1 or address 3 change no register. Control bits 7:6 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_init_i | input | 1 | Raw INIT line from host |
| host_autofd_i | input | 1 | Raw AUTOFD line from host |
| host_strobe_i | input | 1 | Raw STROBE line from host |
| host_selin_i | input | 1 | Raw SELECTIN line from host |
| pd_i | input | DW | Raw data bus input |
| pd_o | output | DW | Data bus drive value |
| pd_oe_o | output | 1 | Data bus drive enable |
| sm_ack_i | input | 1 | ACK assertion from handshake state machine |
| sm_busy_i | input | 1 | BUSY level from handshake state machine |
| ack_o | output | 1 | ACK pin level |
| busy_o | output | 1 | BUSY pin level |
| perror_o | output | 1 | PERROR pin level |
| cpu_wr_i | input | 1 | CPU write strobe |
| cpu_rd_i | input | 1 | CPU read strobe (for side effects) |
| cpu_addr_i | input | 2 | Register address |
| cpu_wdata_i | input | DW | Write data |
| cpu_rdata_o | output | DW | Read data, combinational on address |
| dma_ack_i | input | 1 | DMA acknowledge |
| dma_req_o | output | 1 | DMA request |

## Verification
A corrupted edge-history flop shows up as a missed or an extra capture. It appears on the data readback and on `dma_req_o` one clock after the conditioned strobe falls, so each strobe scenario compares both. A stability counter that is off by one moves the status bit a cycle early or late. A short host pulse then leaks through. The bench samples the status on the exact edges where a level must and must not have arrived. A wrong force bit or a wrong merge shows up at once, in the same cycle, on `ack_o` and `busy_o` and on their readback.

// File: rtl/ppr_pkg.sv
package ppr_pkg;

    localparam int DW   = 8;
    localparam int NCTL = 4;

    // control-line index within the conditioned vector
    localparam int CI_INIT = 0;
    localparam int CI_AFD  = 1;
    localparam int CI_STB  = 2;
    localparam int CI_SEL  = 3;

    typedef enum logic [1:0] {
        A_DATA = 2'd0,
        A_CMD  = 2'd1,
        A_CTRL = 2'd2,
        A_STAT = 2'd3
    } addr_e;

    typedef struct packed {
        logic [1:0] rsvd;
        logic       perror;
        logic       busy_force;
        logic       ack_force;
        logic       filt_en;
        logic       dma_en;
        logic       out_en;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{rsvd: 2'b00, perror: 1'b0, busy_force: 1'b1,
                                   ack_force: 1'b0, filt_en: 1'b0, dma_en: 1'b0,
                                   out_en: 1'b0};

endpackage

// File: rtl/ppr_sync2.sv
module ppr_sync2 #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: RST_VAL, s2: RST_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.s2;

endmodule

// File: rtl/ppr_glitch_filter.sv
module ppr_glitch_filter #(
    parameter int           W        = 4,
    parameter int           FILT_LEN = 3,
    parameter logic [W-1:0] RST_VAL  = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic [W-1:0] sync_i,
    output logic [W-1:0] lvl_o
);

    localparam int CW = $clog2(FILT_LEN) + 1;
    localparam logic [CW-1:0] CNT_TOP = CW'(FILT_LEN - 1);

    typedef struct packed {
        logic [W-1:0]          lvl;
        logic [W-1:0][CW-1:0]  cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < W; i++) begin
            if (!en_i) begin
                st_d.lvl[i] = sync_i[i];
                st_d.cnt[i] = '0;
            end else if (sync_i[i] == st_q.lvl[i]) begin
                st_d.cnt[i] = '0;
            end else if (st_q.cnt[i] == CNT_TOP) begin
                st_d.lvl[i] = sync_i[i];
                st_d.cnt[i] = '0;
            end else begin
                st_d.cnt[i] = st_q.cnt[i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{lvl: RST_VAL, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o = st_q.lvl;

    for (genvar g = 0; g < W; g++) begin : g_chk
        AST_FILT_FROM_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(st_q.lvl[g]) |-> (st_q.lvl[g] == $past(sync_i[g]))); // R7
    end

endmodule

// File: rtl/ppr_capture.sv
module ppr_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe_f_i,
    input  logic [DW-1:0] pd_s_i,
    input  logic          autofd_s_i,
    input  logic          out_en_i,
    input  logic          dma_en_i,
    input  logic          wr_data_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          rd_clr_i,
    input  logic          dma_ack_i,
    output logic [DW-1:0] data_o,
    output logic          cmd_o,
    output logic          dma_req_o
);

    typedef struct packed {
        logic          strb_prev;
        logic [DW-1:0] data;
        logic          cmd;
        logic          req;
    } st_t;

    st_t  st_d, st_q;
    logic cap_evt;

    assign cap_evt = st_q.strb_prev & ~strobe_f_i & ~out_en_i;

    always_comb begin
        st_d           = st_q;
        st_d.strb_prev = strobe_f_i;
        if (wr_data_i) begin
            st_d.data = wdata_i;
        end else if (cap_evt) begin
            st_d.data = pd_s_i;
        end
        if (cap_evt) begin
            st_d.cmd = autofd_s_i;
        end
        if (cap_evt && dma_en_i) begin
            st_d.req = 1'b1;
        end else if (dma_ack_i || rd_clr_i) begin
            st_d.req = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{strb_prev: 1'b1, data: '0, cmd: 1'b0, req: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o    = st_q.data;
    assign cmd_o     = st_q.cmd;
    assign dma_req_o = st_q.req;

    AST_HOLD_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en_i && !wr_data_i) |=> $stable(data_o)); // R1
    AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req_o) |-> $past(dma_en_i)); // R4
    AST_REQ_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ack_i && !cap_evt) |=> !dma_req_o); // R5

endmodule

// File: rtl/ppr_periph_regs.sv
module ppr_periph_regs
    import ppr_pkg::*;
#(
    parameter int DW       = ppr_pkg::DW,
    parameter int FILT_LEN = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_init_i,
    input  logic          host_autofd_i,
    input  logic          host_strobe_i,
    input  logic          host_selin_i,
    input  logic [DW-1:0] pd_i,
    output logic [DW-1:0] pd_o,
    output logic          pd_oe_o,
    input  logic          sm_ack_i,
    input  logic          sm_busy_i,
    output logic          ack_o,
    output logic          busy_o,
    output logic          perror_o,
    input  logic          cpu_wr_i,
    input  logic          cpu_rd_i,
    input  logic [1:0]    cpu_addr_i,
    input  logic [DW-1:0] cpu_wdata_i,
    output logic [DW-1:0] cpu_rdata_o,
    input  logic          dma_ack_i,
    output logic          dma_req_o
);

    localparam int SW = DW + NCTL;
    localparam logic [SW-1:0] SYNC_RST = {{NCTL{1'b1}}, {DW{1'b0}}};

    ctrl_t ctrl_d, ctrl_q;

    logic [SW-1:0]   sync_vec;
    logic [NCTL-1:0] ctl_f;
    logic [DW-1:0]   data_reg;
    logic            cmd_flag;
    logic            wr_data, rd_clr;

    ppr_sync2 #(.W(SW), .RST_VAL(SYNC_RST)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({host_selin_i, host_strobe_i, host_autofd_i, host_init_i, pd_i}),
        .sync_o  (sync_vec)
    );

    ppr_glitch_filter #(.W(NCTL), .FILT_LEN(FILT_LEN), .RST_VAL({NCTL{1'b1}})) i_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (ctrl_q.filt_en),
        .sync_i (sync_vec[SW-1:DW]),
        .lvl_o  (ctl_f)
    );

    assign wr_data = cpu_wr_i && (cpu_addr_i == A_DATA);
    assign rd_clr  = cpu_rd_i && ctrl_q.dma_en &&
                     ((cpu_addr_i == A_DATA) || (cpu_addr_i == A_CMD));

    ppr_capture #(.DW(DW)) i_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_f_i (ctl_f[CI_STB]),
        .pd_s_i     (sync_vec[DW-1:0]),
        .autofd_s_i (sync_vec[DW + CI_AFD]),
        .out_en_i   (ctrl_q.out_en),
        .dma_en_i   (ctrl_q.dma_en),
        .wr_data_i  (wr_data),
        .wdata_i    (cpu_wdata_i),
        .rd_clr_i   (rd_clr),
        .dma_ack_i  (dma_ack_i),
        .data_o     (data_reg),
        .cmd_o      (cmd_flag),
        .dma_req_o  (dma_req_o)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        if (cpu_wr_i && (cpu_addr_i == A_CTRL)) begin
            ctrl_d      = ctrl_t'(cpu_wdata_i[7:0]);
            ctrl_d.rsvd = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ack_o    = ~(ctrl_q.ack_force | sm_ack_i);
    assign busy_o   = ctrl_q.busy_force | sm_busy_i;
    assign perror_o = ctrl_q.perror;
    assign pd_oe_o  = ctrl_q.out_en;
    assign pd_o     = data_reg;

    always_comb begin
        cpu_rdata_o = '0;
        case (addr_e'(cpu_addr_i))
            A_DATA:  cpu_rdata_o = data_reg;
            A_CMD:   cpu_rdata_o = DW'(cmd_flag);
            A_CTRL:  cpu_rdata_o = DW'(ctrl_q);
            default: cpu_rdata_o = DW'({busy_o, ack_o, ctl_f});
        endcase
    end

    AST_ACK_SM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sm_ack_i |-> !ack_o); // R8
    AST_BUSY_SM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sm_busy_i |-> busy_o); // R9
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr_i |=> (ctrl_q.rsvd == 2'b00)); // R12

endmodule

// File: tb/test_ppr_periph_regs.sv
module test_ppr_periph_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       init_r = 1'b1, afd_r = 1'b1, stb_r = 1'b1, sel_r = 1'b1;
    logic [7:0] pd_r = 8'h00;
    logic [7:0] pd_o;
    logic       pd_oe;
    logic       sm_ack = 1'b0, sm_busy = 1'b0;
    logic       ack, busy, perr;
    logic       wr = 1'b0, rd = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       dack = 1'b0;
    logic       dreq;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #5 clk = ~clk;

    ppr_periph_regs i_ppr_periph_regs (
        .clk(clk), .rst_n(rst_n),
        .host_init_i(init_r), .host_autofd_i(afd_r),
        .host_strobe_i(stb_r), .host_selin_i(sel_r),
        .pd_i(pd_r), .pd_o(pd_o), .pd_oe_o(pd_oe),
        .sm_ack_i(sm_ack), .sm_busy_i(sm_busy),
        .ack_o(ack), .busy_o(busy), .perror_o(perr),
        .cpu_wr_i(wr), .cpu_rd_i(rd), .cpu_addr_i(addr),
        .cpu_wdata_i(wdata), .cpu_rdata_o(rdata),
        .dma_ack_i(dack), .dma_req_o(dreq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic strobe_byte(input logic [7:0] d, input logic af);
        @(negedge clk);
        pd_r = d; afd_r = af;
        wait_n(3);
        stb_r = 1'b0;
        wait_n(8);
        stb_r = 1'b1;
        wait_n(8);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        cpu_read(2'd2, v); chk("R10 ctrl reset", v, 8'h10);
        cpu_read(2'd3, v); chk("R10 status reset", v, 8'h3F);
        cpu_read(2'd0, v); chk("R10 data reset", v, 8'h00);
        cpu_read(2'd1, v); chk("R10 cmd reset", v, 8'h00);
        chk("R10 busy/ack/dreq/oe", {busy, ack, dreq, pd_oe}, 4'b1100);
    endtask

    task automatic t_capture;
        logic [7:0] v;
        strobe_byte(8'hA5, 1'b0);
        cpu_read(2'd0, v); chk("R1 capture A5", v, 8'hA5);
        cpu_read(2'd1, v); chk("R3 cmd low", v, 8'h00);
        strobe_byte(8'h3C, 1'b1);
        cpu_read(2'd0, v); chk("R1 capture 3C", v, 8'h3C);
        cpu_read(2'd1, v); chk("R3 cmd high", v, 8'h01);
        pd_r = 8'hFF;
        wait_n(10);
        cpu_read(2'd0, v); chk("R1 no edge no load", v, 8'h3C);
    endtask

    task automatic t_drive;
        logic [7:0] v;
        cpu_write(2'd2, 8'h01);
        cpu_write(2'd0, 8'h81);
        wait_n(1);
        chk("R2 oe and pd_o", {pd_oe, pd_o}, {1'b1, 8'h81});
        strobe_byte(8'h55, 1'b1);
        cpu_read(2'd0, v); chk("R1 no capture while driving", v, 8'h81);
        chk("R2 pd_o held", pd_o, 8'h81);
        cpu_write(2'd2, 8'h00);
        wait_n(1);
        chk("R2 oe off", pd_oe, 1'b0);
    endtask

    task automatic t_dma;
        logic [7:0] v;
        cpu_write(2'd2, 8'h02);
        strobe_byte(8'h11, 1'b1);
        chk("R4 req on capture", dreq, 1'b1);
        @(negedge clk); dack = 1'b1;
        @(negedge clk); dack = 1'b0;
        chk("R5 ack clears", dreq, 1'b0);
        strobe_byte(8'h22, 1'b1);
        cpu_read(2'd2, v);
        chk("R5 ctrl read keeps req", dreq, 1'b1);
        cpu_read(2'd0, v);
        chk("R5 data read clears", {dreq, v}, {1'b0, 8'h22});
        strobe_byte(8'h33, 1'b0);
        cpu_read(2'd1, v);
        chk("R5 cmd read clears", {dreq, v}, {1'b0, 8'h00});
        cpu_write(2'd2, 8'h00);
        strobe_byte(8'h44, 1'b1);
        chk("R4 no req when disabled", dreq, 1'b0);
    endtask

    task automatic t_status_nofilt;
        @(negedge clk);
        addr = 2'd3;
        stb_r = 1'b0;
        wait_n(2);
        chk("R6 strobe not yet after 2", rdata[2], 1'b1);
        wait_n(1);
        chk("R6 strobe low after 3", rdata[2], 1'b0);
        sel_r = 1'b0;
        wait_n(3);
        chk("R6 selin low", rdata[3:0], 4'b0011);
        stb_r = 1'b1; sel_r = 1'b1;
        wait_n(6);
    endtask

    task automatic t_filter;
        cpu_write(2'd2, 8'h04);
        @(negedge clk);
        addr = 2'd3;
        init_r = 1'b0;
        wait_n(2);
        init_r = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (rdata[0] !== 1'b1) begin
                chk("R7 short pulse rejected", rdata[0], 1'b1);
                break;
            end
        end
        chk("R7 short pulse rejected", rdata[0], 1'b1);
        init_r = 1'b0;
        wait_n(4);
        chk("R7 not accepted at 4", rdata[0], 1'b1);
        wait_n(1);
        chk("R7 accepted at 5", rdata[0], 1'b0);
        init_r = 1'b1;
        wait_n(8);
        cpu_write(2'd2, 8'h00);
    endtask

    task automatic t_ack_busy;
        logic [7:0] v;
        cpu_write(2'd2, 8'h00);
        cpu_read(2'd3, v);
        chk("R9 busy low, readback", {busy, v[5]}, 2'b00);
        sm_busy = 1'b1;
        #1 chk("R9 sm busy", busy, 1'b1);
        cpu_read(2'd3, v); chk("R9 readback high", v[5], 1'b1);
        sm_busy = 1'b0;
        cpu_write(2'd2, 8'h10);
        wait_n(1);
        chk("R9 force busy", busy, 1'b1);
        cpu_write(2'd2, 8'h08);
        cpu_read(2'd3, v);
        chk("R8 force ack low, readback", {ack, v[4]}, 2'b00);
        cpu_write(2'd2, 8'h00);
        wait_n(1);
        chk("R8 ack idle high", ack, 1'b1);
        sm_ack = 1'b1;
        #1 chk("R8 sm ack low", ack, 1'b0);
        sm_ack = 1'b0;
    endtask

    task automatic t_perror_ignore;
        logic [7:0] v;
        cpu_write(2'd2, 8'h20);
        wait_n(1); chk("R11 perror high", perr, 1'b1);
        cpu_write(2'd2, 8'h00);
        wait_n(1); chk("R11 perror low", perr, 1'b0);
        cpu_write(2'd0, 8'h5A);
        cpu_write(2'd3, 8'hFF);
        cpu_write(2'd1, 8'hFF);
        cpu_read(2'd2, v); chk("R12 ctrl untouched", v, 8'h00);
        cpu_read(2'd0, v); chk("R12 data untouched", v, 8'h5A);
        cpu_write(2'd2, 8'hC0);
        cpu_read(2'd2, v); chk("R12 reserved read zero", v, 8'h00);
    endtask

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        t_reset();
        t_capture();
        t_drive();
        t_dma();
        t_status_nofilt();
        t_filter();
        t_ack_busy();
        t_perror_ignore();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

endmodule